// File: doc/BRIEF.md
# Pipeline Bubble Accounting Counters

This block holds a set of performance counters for an in-order pipeline. In every enabled cycle it counts clock cycles, instructions retired, and bubbles that reach the end of the pipe. It also keeps one penalty counter for each hazard cause. Each penalty counter adds a fixed number of bubbles per event: 1 for a load-use stall, 2 for a mispredicted branch and 3 for a return. Software reads the totals and works out CPI as 1 + bubbles / retired. The block does no division.

The block also checks its own books. Every enabled cycle must retire exactly one thing, either an instruction or a bubble, so the cycle count must equal retired plus bubbles. The penalty counters credit a cause's full bubble weight when the event arrives, while the matching bubbles drain out over the following cycles. An internal credit counter tracks the bubbles still owed, so the cause sum must equal the bubble total plus that credit. A failure of either identity sets a sticky error flag. The check stops as soon as any counter saturates, because saturated counts no longer add up.

Top module: `bubble_acct_top`

## Requirements
- R1: In every cycle with enable high and clear low, the cycle counter (read select 0) increases by one.
- R2: The retired counter (select 1) counts cycles with the retire pulse high, and the bubble total (select 2) counts cycles with the bubble pulse high, both only while enabled.
- R3: Each enabled load-use event adds 1 to the load penalty counter (select 3).
- R4: Each enabled mispredict event adds 2 to the mispredict penalty counter (select 4).
- R5: Each enabled return event adds 3 to the return penalty counter (select 5).
- R6: Every counter saturates at all ones and never wraps, including when a step of 2 or 3 would cross the maximum.
- R7: A clear high at a clock edge zeroes all six counters, the owed credit and the error flag, and it wins over enable.
- R8: With enable low, every counter holds whatever the pulse inputs do.
- R9: The error flag rises when the cycle count differs from retired plus bubbles, for example after a cycle with both retire and bubble or with neither.
- R10: The error flag rises when the penalty sum differs from the bubble total plus the bubbles still owed. A bubble with no outstanding cause credit does this. Owed bubbles that have not yet arrived do not.
- R11: The error flag is sticky until clear, and it is not raised while any counter sits at its maximum.
- R12: Read selects 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of all counters and the error flag |
| en_i | input | 1 | Counting enable |
| retire_i | input | 1 | An instruction retires this cycle |
| bubble_i | input | 1 | A bubble retires this cycle |
| ld_evt_i | input | 1 | Load-use stall event |
| br_evt_i | input | 1 | Branch mispredict event |
| ret_evt_i | input | 1 | Return event |
| rd_sel_i | input | 3 | Counter select (0 cycles, 1 retired, 2 bubbles, 3 load, 4 mispredict, 5 return) |
| rd_data_o | output | CNT_W | Selected counter value |
| err_o | output | 1 | Sticky accounting error flag |

## Verification
The bench uses 8-bit counters so that it can drive the cycle and return counters to saturation. That exposes a design that wraps or that overshoots on a 3-bubble step. It checks that a return whose bubbles are still owed leaves the flag low. A design that compares the cause sum with the bubble total directly would raise the flag there by mistake. It runs three separate faults, both pulses at once, neither pulse, and a bubble with no cause, to catch a flag that is missing, not sticky, or not cleared. It also checks that enable low freezes every counter across all 32 input patterns, and that the flag stays low once a counter is saturated.

// File: rtl/bubble_acct_pkg.sv
package bubble_acct_pkg;
  localparam int NUM_CTR = 6;
  localparam int INC_W   = 2;
  localparam int LD_WT   = 1;
  localparam int BR_WT   = 2;
  localparam int RT_WT   = 3;

  typedef enum logic [2:0] {
    SEL_CYC = 3'd0,
    SEL_RTR = 3'd1,
    SEL_BUB = 3'd2,
    SEL_LDP = 3'd3,
    SEL_MPP = 3'd4,
    SEL_RTP = 3'd5
  } ctr_sel_e;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W  = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt,
  output logic          sat
);
  function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [IW-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + (W+1)'(b);
    return s[W] ? {W{1'b1}} : s[W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= sat_add(cnt, inc);
  end

  assign sat = (cnt == {W{1'b1}});

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt));
  assert_sat_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !clr) |=> sat);
endmodule

// File: rtl/acct_checker.sv
module acct_checker #(
  parameter int CW = 32,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          bubble_i,
  input  logic          ld_i,
  input  logic          br_i,
  input  logic          ret_i,
  input  logic [CW-1:0] cyc_cnt,
  input  logic [CW-1:0] rtr_cnt,
  input  logic [CW-1:0] bub_cnt,
  input  logic [CW-1:0] ldp_cnt,
  input  logic [CW-1:0] mpp_cnt,
  input  logic [CW-1:0] rtp_cnt,
  input  logic          sat_any,
  output logic          err_o
);
  import bubble_acct_pkg::*;

  logic [OW-1:0] owed_q;
  logic [2:0]    credit_add;
  logic          mm_cycle;
  logic          mm_cause;

  function automatic logic [OW-1:0] credit_next(input logic [OW-1:0] cur,
                                                input logic [2:0] add,
                                                input logic take);
    logic [OW:0] s;
    s = {1'b0, cur} + (OW+1)'(add);
    if (s[OW]) s = {1'b0, {OW{1'b1}}};
    if (take && s != '0) s = s - 1'b1;
    return s[OW-1:0];
  endfunction

  assign credit_add = (ld_i  ? 3'(LD_WT) : 3'd0)
                    + (br_i  ? 3'(BR_WT) : 3'd0)
                    + (ret_i ? 3'(RT_WT) : 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     owed_q <= '0;
    else if (clr_i) owed_q <= '0;
    else if (en_i)  owed_q <= credit_next(owed_q, credit_add, bubble_i);
  end

  assign mm_cycle = ({1'b0, cyc_cnt} != ({1'b0, rtr_cnt} + {1'b0, bub_cnt}));
  assign mm_cause = (({2'b0, ldp_cnt} + {2'b0, mpp_cnt} + {2'b0, rtp_cnt})
                     != ({2'b0, bub_cnt} + (CW+2)'(owed_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_o <= 1'b0;
    else if (clr_i) err_o <= 1'b0;
    else if (!sat_any && (mm_cycle || mm_cause)) err_o <= 1'b1;
  end

  assert_err_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_cycle && !sat_any && !clr_i) |=> err_o);
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_cause && !sat_any && !clr_i) |=> err_o);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);
  assert_err_quiet_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && sat_any) |=> !err_o);
  assert_err_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !err_o);
endmodule

// File: rtl/bubble_acct_top.sv
module bubble_acct_top #(
  parameter int CNT_W    = 32,
  parameter int CREDIT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             retire_i,
  input  logic             bubble_i,
  input  logic             ld_evt_i,
  input  logic             br_evt_i,
  input  logic             ret_evt_i,
  input  logic [2:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             err_o
);
  import bubble_acct_pkg::*;

  logic [INC_W-1:0] inc_a [NUM_CTR];
  logic [CNT_W-1:0] cnt_a [NUM_CTR];
  logic             sat_a [NUM_CTR];
  logic             sat_any;

  always_comb begin
    inc_a[SEL_CYC] = INC_W'(1);
    inc_a[SEL_RTR] = INC_W'(retire_i);
    inc_a[SEL_BUB] = INC_W'(bubble_i);
    inc_a[SEL_LDP] = ld_evt_i  ? INC_W'(LD_WT) : '0;
    inc_a[SEL_MPP] = br_evt_i  ? INC_W'(BR_WT) : '0;
    inc_a[SEL_RTP] = ret_evt_i ? INC_W'(RT_WT) : '0;
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    sat_counter #(.W(CNT_W), .IW(INC_W)) u_ctr (
      .clk (clk),
      .rst_n (rst_n),
      .clr (clr_i),
      .en  (en_i),
      .inc (inc_a[g]),
      .cnt (cnt_a[g]),
      .sat (sat_a[g])
    );
  end

  always_comb begin
    sat_any = 1'b0;
    for (int i = 0; i < NUM_CTR; i++) sat_any = sat_any | sat_a[i];
  end

  acct_checker #(.CW(CNT_W), .OW(CREDIT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .en_i     (en_i),
    .bubble_i (bubble_i),
    .ld_i     (ld_evt_i),
    .br_i     (br_evt_i),
    .ret_i    (ret_evt_i),
    .cyc_cnt  (cnt_a[SEL_CYC]),
    .rtr_cnt  (cnt_a[SEL_RTR]),
    .bub_cnt  (cnt_a[SEL_BUB]),
    .ldp_cnt  (cnt_a[SEL_LDP]),
    .mpp_cnt  (cnt_a[SEL_MPP]),
    .rtp_cnt  (cnt_a[SEL_RTP]),
    .sat_any  (sat_any),
    .err_o    (err_o)
  );

  always_comb begin
    if (rd_sel_i < 3'(NUM_CTR)) rd_data_o = cnt_a[rd_sel_i];
    else                        rd_data_o = '0;
  end

  assert_read_unused_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_i > 3'd5) |-> rd_data_o == '0);
  assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && !sat_a[SEL_CYC]) |=>
      cnt_a[SEL_CYC] == CNT_W'($past(cnt_a[SEL_CYC]) + 1'b1));
  assert_ret_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && ret_evt_i && cnt_a[SEL_RTP] < CNT_W'(8)) |=>
      cnt_a[SEL_RTP] == CNT_W'($past(cnt_a[SEL_RTP]) + 2'd3));
endmodule

// File: tb/tb_bubble_acct_top.sv
`timescale 1ns/1ps
module tb_bubble_acct_top;
  localparam int W   = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, en = 1'b0, rt = 1'b0, bb = 1'b0, ld = 1'b0, br = 1'b0, rv = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [W-1:0] rdata;
  logic err;

  int n_checks = 0;
  int n_errors = 0;
  int expv [6];
  bit done = 0;

  always #2.5 clk = ~clk;

  bubble_acct_top #(.CNT_W(W), .CREDIT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .retire_i(rt),
    .bubble_i(bb), .ld_evt_i(ld), .br_evt_i(br), .ret_evt_i(rv),
    .rd_sel_i(sel), .rd_data_o(rdata), .err_o(err)
  );

  function automatic int sadd(int a, int b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  task automatic check(string req, int act, int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic step(bit e, bit r, bit b, bit l, bit m, bit t);
    @(negedge clk);
    en = e; rt = r; bb = b; ld = l; br = m; rv = t; clr = 1'b0;
    @(posedge clk);
    if (e) begin
      expv[0] = sadd(expv[0], 1);
      expv[1] = sadd(expv[1], int'(r));
      expv[2] = sadd(expv[2], int'(b));
      expv[3] = sadd(expv[3], l ? 1 : 0);
      expv[4] = sadd(expv[4], m ? 2 : 0);
      expv[5] = sadd(expv[5], t ? 3 : 0);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    en = 1'b0; rt = 1'b0; bb = 1'b0; ld = 1'b0; br = 1'b0; rv = 1'b0; clr = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1; en = 1'b1; rt = 1'b1; bb = 1'b1; ld = 1'b1; br = 1'b1; rv = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 6; i++) expv[i] = 0;
    idle();
  endtask

  task automatic check_counts(string req);
    idle();
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      sel = 3'(s);
      #1;
      check($sformatf("%s sel%0d", req, s), int'(rdata), expv[s]);
    end
  endtask

  task automatic check_err(string req, bit exp_e);
    idle();
    @(negedge clk);
    @(negedge clk);
    check(req, int'(err), int'(exp_e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) expv[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_counts("R7 reset state");
    check_err("R11 reset flag low", 1'b0);

    // R1 R2 R3 R4 R5: legal mix, bubbles follow their causes
    for (int i = 0; i < 24; i++) begin
      case (i % 4)
        0: step(1, 1, 0, 0, 0, 0);
        1: step(1, 0, 1, 1, 0, 0);
        2: begin step(1, 0, 1, 0, 1, 0); step(1, 0, 1, 0, 0, 0); end
        default: begin
          step(1, 0, 1, 0, 0, 1);
          step(1, 0, 1, 0, 0, 0);
          if (i == 3) check_err("R10 owed bubbles pending no error", 1'b0);
          step(1, 0, 1, 0, 0, 0);
        end
      endcase
    end
    check_counts("R1-mix R2 R3 R4 R5 counts");
    check_err("R10 legal mix no error", 1'b0);

    // R8: enable low over all 32 pulse patterns
    for (int p = 0; p < 32; p++)
      step(0, p[0], p[1], p[2], p[3], p[4]);
    check_counts("R8 hold with enable low");
    check_err("R8 no error while held", 1'b0);

    // R7: clear wins over enable and pulses
    do_clear();
    check_counts("R7 clear zeroes");

    // R9: retire and bubble together (cause credit supplied)
    step(1, 1, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    check_err("R9 both pulses sets flag", 1'b1);
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    check_err("R11 flag sticky", 1'b1);
    do_clear();
    check_err("R7 clear drops flag", 1'b0);

    // R9: neither pulse
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    check_err("R9 empty cycle sets flag", 1'b1);
    do_clear();

    // R10: bubble with no cause credit
    step(1, 0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    check_err("R10 uncaused bubble sets flag", 1'b1);
    do_clear();
    check_err("R7 clear after R10", 1'b0);

    // R6 and R11: saturation, flag suppressed
    for (int i = 0; i < 260; i++) step(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 90; i++) step(1, 0, 1, 0, 0, 1);
    for (int i = 0; i < 130; i++) step(1, 0, 1, 0, 1, 0);
    check_counts("R6 saturation");
    check(" R6 cycles at max", expv[0], MAXV);
    check(" R6 return penalty at max", expv[5], MAXV);
    check_err("R11 no flag once saturated", 1'b0);

    // R12: unused selects
    for (int s = 6; s < 8; s++) begin
      @(negedge clk);
      sel = 3'(s);
      #1;
      check($sformatf("R12 sel%0d reads zero", s), int'(rdata), 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule